// File: doc/BRIEF.md
# Hardware Error Interrupt Dispatcher

This block sits on a CPU node and collects the one-cycle error-detect pulses that the cache, the system bus interface and the memory-reply path produce. Each pulse carries an error class and a flag that says whether this node started the transaction. From these the block builds two outputs. The first is a hardware error interrupt, a level that stays high until software clears it. The second is a machine-check request, a one-cycle pulse. Whether an error also needs a machine check depends on two things: who started the transaction, and whether EDC correction is turned on.

The block also watches the command/address cycles that this node issues. A cycle that gets no acknowledgement inside a fixed window pulls the shared, wired bus error line for one cycle. Other nodes see that line rise and record a bystander error, which raises the interrupt alone. A small register port gives software the sticky status bits, a capture of the first error, write-one-to-clear, the correctable-error masks and two control bits. The acknowledge tracker is a three-state machine:

- `ACK_IDLE` moves to `ACK_WAIT` on `ca_issue`.
- `ACK_WAIT` returns to `ACK_IDLE` on `ca_ack`. It moves to `ACK_MISS` when the window runs out without an acknowledgement.
- `ACK_MISS` drives the bus error line for one cycle, then returns to `ACK_IDLE`.
- `ca_issue` is accepted only in `ACK_IDLE`.

Top module: `hw_err_dispatch`

## Requirements
- R1: Input class codes are as follows:
  - 0: cache tag parity
  - 1: cache data uncorrectable
  - 2: cache data single-bit
  - 3: duplicate-tag parity
  - 4: memory correctable

  Codes 5 to 7 on `err_class` are ignored: no status bit, no interrupt and no machine check. Internally, class 5 is the missed acknowledgement and class 6 is the bystander bus error.
- R2: A class 0 or 1 error with `err_local`=1 pulses `mchk` for exactly the cycle after the error and raises `hw_irq`. The same error with `err_local`=0 raises `hw_irq` only.
- R3: A class 2 error pulses `mchk` only when `err_local`=1 and EDC correction is disabled. The EDC correction enable is control register bit 0.
- R4: A class 3 error sets status bit 3 and raises `hw_irq`, and never pulses `mchk`.
- R5: Each correctable source has its own mask bit, applied at detection: mask bit 0 for class 2 and mask bit 1 for class 4. A masked event sets no status bit, raises no interrupt and does not drive the bus line. The machine-check rule of R3 still applies to a masked class 2 error.
- R6: A class 4 error sets status bit 4. When the report enable (control bit 1) is 1, it also drives `bus_err_out` for one cycle and raises `hw_irq`. When the report enable is 0, it does neither.
- R7: After `ca_issue`, an acknowledgement in any of the next ACK_WIN cycles (default 4) ends the window quietly. With no acknowledgement, in the cycle after the last window cycle:
  - status bit 5 is set;
  - `mchk` pulses;
  - `bus_err_out` is high for one cycle.
- R8: A rising edge on `bus_err_in` while `bus_err_out` is low sets status bit 6 and raises `hw_irq` without `mchk`. A line that stays high does not set the bit again.
- R9: `hw_irq` stays high until every bit feeding it is cleared. Bits are cleared by writing ones at the matching positions of the clear register (address 1).
- R10: A clear that lands in the same cycle as a new error of the same bit leaves the bit set.
- R11: Status bit 8 marks a valid first-error capture. Bits 11:9 hold the class of that first error and bit 12 holds its local flag. Later errors do not overwrite the capture. Writing clear bit 8 re-arms the capture.
- R12: After reset the following are all zero:
  - the status register;
  - the masks;
  - the controls;
  - `hw_irq`, `mchk` and `bus_err_out`.
- R13: The mask register (address 2, bits 1:0) and the control register (address 3, bits 1:0) read back the value written. The status register is at address 0. Address 1 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | One-cycle error-detect pulse |
| err_class | input | 3 | Class of the error pulse |
| err_local | input | 1 | 1 when this node started the transaction |
| ca_issue | input | 1 | This node issued a command/address cycle |
| ca_ack | input | 1 | Acknowledgement from a responder |
| bus_err_in | input | 1 | Sampled value of the shared bus error line |
| bus_err_out | output | 1 | Drive request for the shared bus error line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_irq | output | 1 | Level hardware error interrupt |
| mchk | output | 1 | One-cycle machine-check request |

## Verification
The bench places the acknowledgement in the last cycle of the window and also leaves it out altogether. A tracker off by one either reports a miss that was answered, or reports it a cycle late. It raises an error in the same cycle that software clears that bit, and it clears the first-error flag while a new error arrives. A design where the clear wins loses the event. The bench holds the bus error line high through this node's own drive cycle and past a clear. A missing self-filter or a level-sensitive detector then shows up as a false bystander bit. The bench also exercises the following, which a design that gated the wrong term would get wrong:
- a masked correctable error, which must still raise a machine check;
- a duplicate-tag error from the local node, which must not;
- memory correctable reports with the report enable off, which must stay silent.

// File: rtl/hed_pkg.sv
package hed_pkg;

    localparam int NCLS = 7;

    typedef enum logic [2:0] {
        CLS_TAGPAR = 3'd0,
        CLS_DATAUE = 3'd1,
        CLS_DATACE = 3'd2,
        CLS_DUPTAG = 3'd3,
        CLS_MEMCE  = 3'd4,
        CLS_CANACK = 3'd5,
        CLS_BUSBY  = 3'd6
    } err_cls_e;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_WAIT = 2'd1,
        ACK_MISS = 2'd2
    } ack_st_e;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_CLEAR  = 2'd1;
    localparam logic [1:0] RA_MASK   = 2'd2;
    localparam logic [1:0] RA_CTRL   = 2'd3;

    localparam int FV_BIT = 8;
    localparam int FC_LSB = 9;
    localparam int FL_BIT = 12;

endpackage

// File: rtl/hed_ack_fsm.sv
module hed_ack_fsm
    import hed_pkg::*;
#(
    parameter int ACK_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ca_issue,
    input  logic ca_ack,
    input  logic bus_err_in,
    input  logic mem_drive,
    output logic nack_evt,
    output logic by_evt,
    output logic bus_err_out
);

    localparam int CW = (ACK_WIN < 2) ? 1 : $clog2(ACK_WIN);
    localparam logic [CW-1:0] LAST = CW'(ACK_WIN - 1);

    ack_st_e       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          line_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            cnt_q   <= '0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            line_q  <= bus_err_in;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ACK_IDLE: begin
                if (ca_issue) begin
                    state_d = ACK_WAIT;
                    cnt_d   = '0;
                end
            end
            ACK_WAIT: begin
                if (ca_ack) begin
                    state_d = ACK_IDLE;
                end else if (cnt_q == LAST) begin
                    state_d = ACK_MISS;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ACK_MISS: state_d = ACK_IDLE;
            default:  state_d = ACK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        nack_evt    = (state_q == ACK_WAIT) && !ca_ack && (cnt_q == LAST);
        bus_err_out = (state_q == ACK_MISS) || mem_drive;
        by_evt      = bus_err_in && !line_q && !bus_err_out;
    end

endmodule

// File: rtl/hed_classify.sv
module hed_classify
    import hed_pkg::*;
(
    input  logic            err_valid,
    input  logic [2:0]      err_class,
    input  logic            err_local,
    input  logic [1:0]      corr_mask,
    input  logic            edc_en,
    input  logic            crd_en,
    input  logic            nack_evt,
    input  logic            by_evt,
    output logic [NCLS-1:0] set_vec,
    output logic            mchk_req,
    output logic            memce_drive,
    output logic            cap_valid,
    output logic [2:0]      cap_class,
    output logic            cap_local
);

    logic in_ok;
    logic masked;
    logic hard_cls;

    always_comb begin
        in_ok    = err_valid && (err_class <= CLS_MEMCE);
        masked   = ((err_class == CLS_DATACE) && corr_mask[0]) ||
                   ((err_class == CLS_MEMCE)  && corr_mask[1]);
        hard_cls = (err_class == CLS_TAGPAR) || (err_class == CLS_DATAUE) ||
                   ((err_class == CLS_DATACE) && !edc_en);

        for (int i = 0; i < 5; i++) begin
            set_vec[i] = in_ok && (err_class == 3'(i)) && !masked;
        end
        set_vec[CLS_CANACK] = nack_evt;
        set_vec[CLS_BUSBY]  = by_evt;

        mchk_req    = nack_evt || (in_ok && err_local && hard_cls);
        memce_drive = in_ok && (err_class == CLS_MEMCE) && !masked && crd_en;

        cap_valid = |set_vec;
        if (nack_evt) begin
            cap_class = CLS_CANACK;
            cap_local = 1'b1;
        end else if (|set_vec[4:0]) begin
            cap_class = err_class;
            cap_local = err_local;
        end else begin
            cap_class = CLS_BUSBY;
            cap_local = 1'b0;
        end
    end

endmodule

// File: rtl/hed_status.sv
module hed_status
    import hed_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] set_vec,
    input  logic            cap_valid,
    input  logic [2:0]      cap_class,
    input  logic            cap_local,
    input  logic            mchk_req,
    input  logic            memce_drive,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            hw_irq,
    output logic            mchk,
    output logic            mem_drive,
    output logic [1:0]      corr_mask,
    output logic            edc_en,
    output logic            crd_en
);

    logic [NCLS-1:0] sticky_q;
    logic [NCLS-1:0] clr_vec;
    logic [NCLS-1:0] irq_vec;
    logic            fv_q, fl_q;
    logic [2:0]      fc_q;
    logic            clr_first;
    logic            fv_live;
    logic [1:0]      ctrl_q;

    always_comb begin
        clr_vec   = '0;
        clr_first = 1'b0;
        if (reg_wr && (reg_addr == RA_CLEAR)) begin
            clr_vec   = reg_wdata[NCLS-1:0];
            clr_first = reg_wdata[FV_BIT];
        end
        fv_live = fv_q && !clr_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q  <= '0;
            fv_q      <= 1'b0;
            fc_q      <= '0;
            fl_q      <= 1'b0;
            corr_mask <= '0;
            ctrl_q    <= '0;
            mchk      <= 1'b0;
            mem_drive <= 1'b0;
        end else begin
            sticky_q  <= (sticky_q & ~clr_vec) | set_vec;
            mchk      <= mchk_req;
            mem_drive <= memce_drive;
            if (!fv_live && cap_valid) begin
                fv_q <= 1'b1;
                fc_q <= cap_class;
                fl_q <= cap_local;
            end else begin
                fv_q <= fv_live;
            end
            if (reg_wr && (reg_addr == RA_MASK)) corr_mask <= reg_wdata[1:0];
            if (reg_wr && (reg_addr == RA_CTRL)) ctrl_q    <= reg_wdata[1:0];
        end
    end

    assign edc_en = ctrl_q[0];
    assign crd_en = ctrl_q[1];

    always_comb begin
        irq_vec            = sticky_q;
        irq_vec[CLS_MEMCE] = sticky_q[CLS_MEMCE] && crd_en;
        hw_irq             = |irq_vec;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STATUS: begin
                reg_rdata[NCLS-1:0]         = sticky_q;
                reg_rdata[FV_BIT]           = fv_q;
                reg_rdata[FC_LSB+2:FC_LSB]  = fc_q;
                reg_rdata[FL_BIT]           = fl_q;
            end
            RA_CLEAR: reg_rdata = '0;
            RA_MASK:  reg_rdata[1:0] = corr_mask;
            RA_CTRL:  reg_rdata[1:0] = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hw_err_dispatch.sv
module hw_err_dispatch
    import hed_pkg::*;
#(
    parameter int ACK_WIN = 4,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_valid,
    input  logic [2:0]    err_class,
    input  logic          err_local,
    input  logic          ca_issue,
    input  logic          ca_ack,
    input  logic          bus_err_in,
    output logic          bus_err_out,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          hw_irq,
    output logic          mchk
);

    logic            nack_evt, by_evt, mem_drive;
    logic [NCLS-1:0] set_vec;
    logic            mchk_req, memce_drive;
    logic            cap_valid, cap_local;
    logic [2:0]      cap_class;
    logic [1:0]      corr_mask;
    logic            edc_en, crd_en;

    hed_ack_fsm #(.ACK_WIN(ACK_WIN)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ca_issue    (ca_issue),
        .ca_ack      (ca_ack),
        .bus_err_in  (bus_err_in),
        .mem_drive   (mem_drive),
        .nack_evt    (nack_evt),
        .by_evt      (by_evt),
        .bus_err_out (bus_err_out)
    );

    hed_classify u_cls (
        .err_valid   (err_valid),
        .err_class   (err_class),
        .err_local   (err_local),
        .corr_mask   (corr_mask),
        .edc_en      (edc_en),
        .crd_en      (crd_en),
        .nack_evt    (nack_evt),
        .by_evt      (by_evt),
        .set_vec     (set_vec),
        .mchk_req    (mchk_req),
        .memce_drive (memce_drive),
        .cap_valid   (cap_valid),
        .cap_class   (cap_class),
        .cap_local   (cap_local)
    );

    hed_status #(.DW(DW)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vec     (set_vec),
        .cap_valid   (cap_valid),
        .cap_class   (cap_class),
        .cap_local   (cap_local),
        .mchk_req    (mchk_req),
        .memce_drive (memce_drive),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .hw_irq      (hw_irq),
        .mchk        (mchk),
        .mem_drive   (mem_drive),
        .corr_mask   (corr_mask),
        .edc_en      (edc_en),
        .crd_en      (crd_en)
    );

endmodule

// File: rtl/hed_chk.sv
module hed_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       err_valid,
    input logic [2:0] err_class,
    input logic       err_local,
    input logic       nack_evt,
    input logic       reg_wr,
    input logic       bus_err_out,
    input logic       hw_irq,
    input logic       mchk
);

    // R2
    ue_local_mchk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_local && (err_class == 3'd0 || err_class == 3'd1)) |=> mchk);

    // R2
    remote_no_mchk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_local && !nack_evt) |=> !mchk);

    // R4
    duptag_no_mchk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_class == 3'd3 && !nack_evt) |=> !mchk);

    // R7
    nack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_evt |=> (bus_err_out && mchk));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_irq && !reg_wr) |=> hw_irq);

endmodule

bind hw_err_dispatch hed_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_valid   (err_valid),
    .err_class   (err_class),
    .err_local   (err_local),
    .nack_evt    (nack_evt),
    .reg_wr      (reg_wr),
    .bus_err_out (bus_err_out),
    .hw_irq      (hw_irq),
    .mchk        (mchk)
);

// File: tb/hw_err_dispatch_test.sv
module hw_err_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_valid = 1'b0;
    logic [2:0]  err_class = '0;
    logic        err_local = 1'b0;
    logic        ca_issue = 1'b0;
    logic        ca_ack = 1'b0;
    logic        bus_err_in = 1'b0;
    logic        bus_err_out;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_irq;
    logic        mchk;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hw_err_dispatch uut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_class(err_class),
        .err_local(err_local), .ca_issue(ca_issue), .ca_ack(ca_ack),
        .bus_err_in(bus_err_in), .bus_err_out(bus_err_out), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_irq(hw_irq), .mchk(mchk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [2:0] c, input logic loc);
        @(negedge clk);
        err_valid = 1'b1; err_class = c; err_local = loc;
        @(negedge clk);
        err_valid = 1'b0; err_class = '0; err_local = 1'b0;
    endtask

    task automatic sticky(output logic [31:0] s);
        logic [31:0] d;
        rd(2'd0, d);
        s = d & 32'h7F;
    endtask

    task automatic clear_all();
        wr(2'd1, 32'h1FFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R12 status", d, 0);
        rd(2'd2, d); check("R12 mask", d, 0);
        rd(2'd3, d); check("R12 ctrl", d, 0);
        check("R12 irq", hw_irq, 0);
        check("R12 mchk", mchk, 0);
        check("R12 bus", bus_err_out, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd2, 32'h3); rd(2'd2, d); check("R13 mask rw", d, 3);
        wr(2'd3, 32'h3); rd(2'd3, d); check("R13 ctrl rw", d, 3);
        rd(2'd1, d); check("R13 clear reads 0", d, 0);
        wr(2'd2, 0); wr(2'd3, 0);
    endtask

    task automatic t_uncorr();
        logic [31:0] s;
        clear_all();
        pulse(3'd0, 1'b1);
        check("R2 tag local mchk", mchk, 1);
        check("R2 tag local irq", hw_irq, 1);
        sticky(s); check("R2 tag bit", s, 32'h1);
        @(negedge clk);
        check("R2 mchk one cycle", mchk, 0);
        clear_all();
        pulse(3'd1, 1'b0);
        check("R2 ue remote no mchk", mchk, 0);
        check("R2 ue remote irq", hw_irq, 1);
        sticky(s); check("R2 ue bit", s, 32'h2);
    endtask

    task automatic t_single();
        clear_all();
        pulse(3'd2, 1'b1);
        check("R3 ce local edc off mchk", mchk, 1);
        wr(2'd3, 32'h1);
        pulse(3'd2, 1'b1);
        check("R3 ce local edc on no mchk", mchk, 0);
        check("R3 ce irq", hw_irq, 1);
        wr(2'd3, 32'h0);
        pulse(3'd2, 1'b0);
        check("R3 ce remote no mchk", mchk, 0);
    endtask

    task automatic t_dup();
        logic [31:0] s;
        clear_all();
        pulse(3'd3, 1'b1);
        check("R4 dup no mchk", mchk, 0);
        check("R4 dup irq", hw_irq, 1);
        sticky(s); check("R4 dup bit", s, 32'h8);
    endtask

    task automatic t_mask();
        logic [31:0] s;
        clear_all();
        wr(2'd2, 32'h1);
        pulse(3'd2, 1'b1);
        check("R5 masked ce still mchk", mchk, 1);
        check("R5 masked ce no irq", hw_irq, 0);
        sticky(s); check("R5 masked ce no bit", s, 0);
        wr(2'd2, 32'h2); wr(2'd3, 32'h2);
        pulse(3'd4, 1'b0);
        check("R5 masked memce no drive", bus_err_out, 0);
        check("R5 masked memce no irq", hw_irq, 0);
        sticky(s); check("R5 masked memce no bit", s, 0);
        wr(2'd2, 0); wr(2'd3, 0);
    endtask

    task automatic t_memce();
        logic [31:0] s;
        clear_all();
        wr(2'd3, 32'h2);
        pulse(3'd4, 1'b0);
        check("R6 memce report drive", bus_err_out, 1);
        check("R6 memce report irq", hw_irq, 1);
        sticky(s); check("R6 memce bit", s, 32'h10);
        @(negedge clk);
        check("R6 drive one cycle", bus_err_out, 0);
        clear_all();
        wr(2'd3, 32'h0);
        pulse(3'd4, 1'b0);
        check("R6 silent no drive", bus_err_out, 0);
        check("R6 silent no irq", hw_irq, 0);
        sticky(s); check("R6 silent bit set", s, 32'h10);
        clear_all();
    endtask

    task automatic t_ack();
        logic [31:0] s;
        clear_all();
        // acknowledgement in the last window cycle
        @(negedge clk); ca_issue = 1'b1;
        @(negedge clk); ca_issue = 1'b0;
        @(negedge clk); @(negedge clk);
        @(negedge clk); ca_ack = 1'b1;
        @(negedge clk); ca_ack = 1'b0;
        check("R7 late ack no mchk", mchk, 0);
        check("R7 late ack no drive", bus_err_out, 0);
        sticky(s); check("R7 late ack no bit", s, 0);
        // no acknowledgement at all
        @(negedge clk); ca_issue = 1'b1;
        @(negedge clk); ca_issue = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R7 no early miss", mchk, 0);
        @(negedge clk);
        check("R7 miss mchk", mchk, 1);
        check("R7 miss drive", bus_err_out, 1);
        sticky(s); check("R7 miss bit", s, 32'h20);
        bus_err_in = 1'b1;
        @(negedge clk);
        check("R7 drive one cycle", bus_err_out, 0);
        bus_err_in = 1'b0;
        @(negedge clk);
        sticky(s); check("R8 own drive not bystander", s, 32'h20);
        clear_all();
    endtask

    task automatic t_bystander();
        logic [31:0] s;
        clear_all();
        @(negedge clk); bus_err_in = 1'b1;
        @(negedge clk);
        sticky(s); check("R8 bystander bit", s, 32'h40);
        check("R8 bystander irq", hw_irq, 1);
        check("R8 bystander no mchk", mchk, 0);
        clear_all();
        @(negedge clk);
        sticky(s); check("R8 held line no retrigger", s, 0);
        check("R9 irq cleared", hw_irq, 0);
        bus_err_in = 1'b0;
    endtask

    task automatic t_hold();
        clear_all();
        pulse(3'd3, 1'b0);
        repeat (5) @(negedge clk);
        check("R9 irq held", hw_irq, 1);
        wr(2'd1, 32'h1);
        check("R9 unrelated clear keeps irq", hw_irq, 1);
        wr(2'd1, 32'h8);
        check("R9 irq drops after clear", hw_irq, 0);
    endtask

    task automatic t_race();
        logic [31:0] s;
        clear_all();
        @(negedge clk);
        err_valid = 1'b1; err_class = 3'd3; err_local = 1'b0;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h8;
        @(negedge clk);
        err_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        sticky(s); check("R10 set wins over clear", s, 32'h8);
        clear_all();
    endtask

    task automatic t_first();
        logic [31:0] d;
        clear_all();
        pulse(3'd1, 1'b1);
        pulse(3'd0, 1'b0);
        rd(2'd0, d);
        check("R11 first valid", d[8], 1);
        check("R11 first class", d[11:9], 1);
        check("R11 first local", d[12], 1);
        wr(2'd1, 32'h100);
        rd(2'd0, d);
        check("R11 first rearmed", d[8], 0);
        check("R11 sticky kept", d[6:0], 32'h3);
        pulse(3'd3, 1'b0);
        rd(2'd0, d);
        check("R11 recapture class", d[11:9], 3);
        check("R11 recapture local", d[12], 0);
        clear_all();
    endtask

    task automatic t_ignored();
        logic [31:0] s;
        clear_all();
        pulse(3'd7, 1'b1);
        check("R1 code7 no mchk", mchk, 0);
        pulse(3'd5, 1'b1);
        check("R1 code5 no mchk", mchk, 0);
        check("R1 ignored no irq", hw_irq, 0);
        sticky(s); check("R1 ignored no bit", s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_uncorr();
        t_single();
        t_dup();
        t_mask();
        t_memce();
        t_ack();
        t_bystander();
        t_hold();
        t_race();
        t_first();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule